// File: doc/BRIEF.md
# Fuse-Programmable Sum-of-Products Logic Device

This block is a small programmable logic device. Ten dedicated inputs and eight feedback signals form eighteen array signals. A programmable AND plane builds product terms from them. Each product term may connect the true form of a signal, its complement, neither, or both. Each of the eight output macrocells owns a group of eight product terms, and a fixed OR gate sums them.

Each macrocell is configured on its own. It is either combinational or registered, its output is active high or active low, and a registered macrocell may use an XOR option. In the combinational mode the first product term of the group drives the pin's output enable, and the other seven form the logic function. In the registered mode the sum is captured on the rising clock edge. With the XOR option set, the lower half of the group and the upper half are ORed separately, and the two results are XORed into the register. Feedback into the array comes from the register for a registered macrocell and from the pad (`pin_in`) for a combinational one.

The whole configuration sits in an internal fuse register. It is loaded one bit per clock, MSB first, while `cfg_load` is high.

Top module: `pal_device`

## Requirements
- R1: Fuse bit `(m*8+p)*36 + 2*s` connects the true form of array signal s to product term p of macrocell m. Bit `(m*8+p)*36 + 2*s + 1` connects its complement. Array signals 0 to 9 are `din[0..9]` and signals 10 to 17 are the feedback of macrocells 0 to 7. A term is the AND of its connected literals.
- R2: A product term with no connection evaluates to 0. A term that connects both forms of one signal evaluates to 0. Neither kind of term changes its output.
- R3: In a combinational macrocell, the output value is the OR of terms 1 to 7 and the output enable is term 0. The value follows the inputs with no clock.
- R4: A registered macrocell captures the OR of all 8 terms on the rising clock edge. Its pin shows the register, and its output enable is always 1 while not loading.
- R5: Configuration bit `FW + 3*m + 1` (FW = 2304) selects active-high output when 1. When it is 0, the pin carries the inverse of the macrocell value.
- R6: Configuration bit `FW + 3*m + 2` selects the XOR option. A registered macrocell then captures OR(terms 0..3) XOR OR(terms 4..7). The bit has no effect on a combinational macrocell.
- R7: Configuration bit `FW + 3*m` = 1 makes the macrocell registered. Its feedback is then the register's true value, taken before the polarity inversion. With the bit at 0 the feedback is `pin_in[m]`.
- R8: While `cfg_load` is high, `cfg_sdi` shifts into the 2328-bit configuration, MSB first. Every `pin_oe` bit is 0 and the macrocell registers hold their value.
- R9: `clr` high at a rising edge sets all macrocell registers to 0 and leaves the configuration unchanged.
- R10: `rst_n` low clears all macrocell registers at once. Its release is synchronised, so the registers stay cleared for two more rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and the configuration shift |
| rst_n | input | 1 | Asynchronous active-low reset of the macrocell registers |
| clr | input | 1 | Synchronous clear of the macrocell registers |
| cfg_load | input | 1 | Configuration shift enable; outputs disabled while high |
| cfg_sdi | input | 1 | Serial configuration data, MSB first |
| din | input | 10 | Dedicated array inputs |
| pin_in | input | 8 | Resolved pad value, feedback for combinational macrocells |
| pin_out | output | 8 | Output value per macrocell |
| pin_oe | output | 8 | Output enable per macrocell |

## Verification
The bench goes after these corner cases:
- **Contradictory and empty terms.** A design that treats these as true would drive a macrocell high on every vector.
- **Feedback taken before the polarity inversion.** A toggling active-low register is chained into a second register. Feedback taken after the inversion would show in that second register as a phase error.
- **XOR option on a combinational macrocell.** The bit must be ignored there, and a design that applies it would change the OR result.
- **Output enable and register hold during a load.** These are checked in the middle of a shift.
- **Synchronous clear and the synchronised reset release.** Clearing the configuration, or releasing the registers early, would make later outputs diverge from the bench model.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned MC_CFG_W = 3;

  typedef struct packed {
    logic xor_en;
    logic act_high;
    logic registered;
  } mc_cfg_t;
endpackage

// File: rtl/pal_fuse_chain.sv
module pal_fuse_chain #(
  parameter int unsigned W = 2328
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         sdi,
  output logic [W-1:0] bits
);
  logic [W-1:0] bits_nxt;

  always_comb begin
    if (load) bits_nxt = {bits[W-2:0], sdi};
    else      bits_nxt = bits;
  end

  always_ff @(posedge clk) begin
    bits <= bits_nxt;
  end

  assert_shift_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bits[0] == $past(sdi));
  assert_shift_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bits[W-1] == $past(bits[W-2]));
  assert_cfg_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bits));
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
  parameter int unsigned N_SIG = 18,
  parameter int unsigned N_PT  = 8,
  localparam int unsigned TW   = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]   sig,
  input  logic [N_PT*TW-1:0] fuse,
  output logic [N_PT-1:0]    term
);
  for (genvar p = 0; p < N_PT; p++) begin : g_term
    logic hit;
    logic used;
    always_comb begin
      hit  = 1'b1;
      used = 1'b0;
      for (int s = 0; s < N_SIG; s++) begin
        if (fuse[p*TW + 2*s]) begin
          used = 1'b1;
          if (!sig[s]) hit = 1'b0;
        end
        if (fuse[p*TW + 2*s + 1]) begin
          used = 1'b1;
          if (sig[s]) hit = 1'b0;
        end
      end
      term[p] = used & hit;
    end
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_pkg::*;
#(
  parameter int unsigned N_PT = 8,
  localparam int unsigned HALF = N_PT / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  mc_cfg_t         cfg,
  input  logic [N_PT-1:0] term,
  input  logic            pad,
  output logic            pin_val,
  output logic            pin_oe,
  output logic            fb
);
  logic or_lo, or_hi, or_all, or_logic;
  logic d, q, q_nxt, val;

  always_comb begin
    or_lo    = |term[HALF-1:0];
    or_hi    = |term[N_PT-1:HALF];
    or_all   = or_lo | or_hi;
    or_logic = |term[N_PT-1:1];
    d        = cfg.xor_en ? (or_lo ^ or_hi) : or_all;
  end

  always_comb begin
    if (clr)      q_nxt = 1'b0;
    else if (run) q_nxt = d;
    else          q_nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  always_comb begin
    val     = cfg.registered ? q : or_logic;
    pin_val = cfg.act_high ? val : ~val;
    pin_oe  = run & (cfg.registered | term[0]);
    fb      = cfg.registered ? q : pad;
  end

  assert_clr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q);
  assert_load_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(q));
  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |=> q == $past(d));
endmodule

// File: rtl/pal_device.sv
module pal_device
  import pal_pkg::*;
#(
  parameter int unsigned N_IN = 10,
  parameter int unsigned N_MC = 8,
  parameter int unsigned N_PT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            cfg_load,
  input  logic            cfg_sdi,
  input  logic [N_IN-1:0] din,
  input  logic [N_MC-1:0] pin_in,
  output logic [N_MC-1:0] pin_out,
  output logic [N_MC-1:0] pin_oe
);
  localparam int unsigned N_SIG  = N_IN + N_MC;
  localparam int unsigned TW     = 2 * N_SIG;
  localparam int unsigned MFW    = N_PT * TW;
  localparam int unsigned FUSE_W = N_MC * MFW;
  localparam int unsigned CFG_W  = FUSE_W + N_MC * MC_CFG_W;

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             run;
  logic [CFG_W-1:0] cfg_bits;
  logic [N_MC-1:0]  fb;
  logic [N_SIG-1:0] sig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end

  always_comb begin
    rst_int_n = rst_sync[1];
    run       = ~cfg_load;
    sig       = {fb, din};
  end

  pal_fuse_chain #(.W(CFG_W)) i_chain (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (cfg_load),
    .sdi   (cfg_sdi),
    .bits  (cfg_bits)
  );

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    logic [N_PT-1:0] term;
    mc_cfg_t         mcfg;

    assign mcfg = mc_cfg_t'(cfg_bits[FUSE_W + m*MC_CFG_W +: MC_CFG_W]);

    pal_and_plane #(.N_SIG(N_SIG), .N_PT(N_PT)) i_plane (
      .sig  (sig),
      .fuse (cfg_bits[m*MFW +: MFW]),
      .term (term)
    );

    pal_macrocell #(.N_PT(N_PT)) i_mc (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .clr     (clr),
      .run     (run),
      .cfg     (mcfg),
      .term    (term),
      .pad     (pin_in[m]),
      .pin_val (pin_out[m]),
      .pin_oe  (pin_oe[m]),
      .fb      (fb[m])
    );
  end

  assert_load_off_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_load |-> pin_oe == '0);
endmodule

// File: tb/test_pal_device.sv
module test_pal_device;
  localparam int NI = 10, NM = 8, NP = 8, NS = 18, TW = 36;
  localparam int FW = NM * NP * TW, CW = FW + NM * 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, clr, cfg_load, cfg_sdi;
  logic [NI-1:0] din;
  logic [NM-1:0] pin_in, pin_out, pin_oe;

  logic [CW-1:0] cfgv;
  logic [NM-1:0] qm;
  bit hold_rst;
  int errors = 0, checks = 0;
  bit done = 0;

  pal_device i_pal_device (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_load(cfg_load), .cfg_sdi(cfg_sdi),
    .din(din), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [NS-1:0] sig_f();
    logic [NM-1:0] f;
    for (int m = 0; m < NM; m++) f[m] = cfgv[FW + 3*m] ? qm[m] : pin_in[m];
    return {f, din};
  endfunction

  function automatic logic term_f(input int t, input logic [NS-1:0] s);
    bit any = 0, r = 1;
    for (int k = 0; k < NS; k++) begin
      if (cfgv[t*TW + 2*k])     begin any = 1; if (!s[k]) r = 0; end
      if (cfgv[t*TW + 2*k + 1]) begin any = 1; if (s[k])  r = 0; end
    end
    return any && r;
  endfunction

  function automatic logic d_f(input int m);
    logic [NS-1:0] s = sig_f();
    logic lo = 0, hi = 0;
    for (int p = 0; p < NP/2; p++)  lo |= term_f(m*NP + p, s);
    for (int p = NP/2; p < NP; p++) hi |= term_f(m*NP + p, s);
    return cfgv[FW + 3*m + 2] ? (lo ^ hi) : (lo | hi);
  endfunction

  function automatic logic [NM-1:0] exp_out();
    logic [NS-1:0] s = sig_f();
    logic [NM-1:0] r;
    for (int m = 0; m < NM; m++) begin
      logic v = 0;
      if (cfgv[FW + 3*m]) v = qm[m];
      else for (int p = 1; p < NP; p++) v |= term_f(m*NP + p, s);
      r[m] = cfgv[FW + 3*m + 1] ? v : ~v;
    end
    return r;
  endfunction

  function automatic logic [NM-1:0] exp_oe();
    logic [NS-1:0] s = sig_f();
    logic [NM-1:0] r;
    for (int m = 0; m < NM; m++)
      r[m] = !cfg_load && (cfgv[FW + 3*m] || term_f(m*NP, s));
    return r;
  endfunction

  task automatic check(input string req, input logic [NM-1:0] act, input logic [NM-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    #1;
    check({req, " out"}, pin_out, exp_out());
    check({req, " oe"}, pin_oe, exp_oe());
  endtask

  task automatic tick();
    logic [NM-1:0] nxt;
    for (int m = 0; m < NM; m++)
      nxt[m] = hold_rst ? 1'b0 : clr ? 1'b0 : cfg_load ? qm[m] : d_f(m);
    @(posedge clk);
    #5;
    qm = nxt;
  endtask

  task automatic load_cfg();
    cfg_load = 1'b1;
    for (int i = CW - 1; i >= 0; i--) begin
      cfg_sdi = cfgv[i];
      tick();
      if (i == CW / 2) begin
        #1;
        check("R8 oe off while loading", pin_oe, '0);
      end
    end
    cfg_load = 1'b0;
  endtask

  task automatic lit(input int m, input int p, input int s, input bit comp);
    cfgv[(m*NP + p)*TW + 2*s + comp] = 1'b1;
  endtask

  task automatic mode(input int m, input bit rg, input bit hi, input bit x);
    cfgv[FW + 3*m +: 3] = {x, hi, rg};
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; clr = 0; cfg_load = 0; cfg_sdi = 0; din = '0; pin_in = '0;
    qm = '0; hold_rst = 1;
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    tick(); tick();
    hold_rst = 0;

    cfgv = '0;
    mode(0, 0, 1, 0); lit(0, 0, 0, 0); lit(0, 1, 1, 0); lit(0, 1, 2, 1); lit(0, 2, 5, 0);
    mode(1, 0, 1, 0); lit(1, 0, 0, 0); lit(1, 1, 3, 0); lit(1, 1, 3, 1);
    mode(2, 1, 1, 1); lit(2, 0, 3, 0); lit(2, 4, 4, 0);
    mode(3, 1, 0, 0); lit(3, 1, 13, 1);
    mode(4, 0, 0, 0); lit(4, 0, 9, 1); lit(4, 1, 14, 0);
    mode(5, 1, 1, 0); lit(5, 0, 3, 0); lit(5, 5, 4, 0); lit(5, 2, 15, 0);
    mode(6, 0, 1, 1); lit(6, 0, 0, 0); lit(6, 1, 3, 0); lit(6, 5, 4, 0);
    mode(7, 1, 1, 0); lit(7, 0, 13, 0);
    load_cfg();
    // R10 reset state: registered macrocells start at 0, mc3 active-low shows 1
    #1;
    check("R10 reset state out", pin_out & 8'hAC, 8'h08);
    check("R4 registered always enabled", pin_oe & 8'hAC, 8'hAC);

    din = 10'b00_0000_0011; pin_in = '0;
    #1;
    check("R1 literal AND din1&~din2", {7'b0, pin_out[0]}, 8'h01);
    check("R2 contradictory term stays 0", {7'b0, pin_out[1]}, 8'h00);
    check("R3 oe from term0", pin_oe & 8'h03, 8'h03);
    din[0] = 1'b0;
    #1;
    check("R3 oe low when term0 false", pin_oe & 8'h03, 8'h00);
    din = 10'b00_0001_1000;
    #1;
    check("R6 xor ignored on combinational", {7'b0, pin_out[6]}, 8'h01);
    tick();
    check("R6 xor of halves is 0 when both set", {7'b0, pin_out[2]}, 8'h00);
    check("R4 plain OR captured", {7'b0, pin_out[5]}, 8'h01);
    check_all("R4 R5 R7 after edge");
    for (int k = 0; k < 12; k++) begin
      din = 10'(k * 37 + 5); pin_in = 8'(k * 19);
      tick();
      check_all("R1 R3 R4 R5 R6 R7 directed");
    end
    pin_in[4] = 1'b1; din[9] = 1'b0;
    #1;
    check("R7 comb feedback from pad, R5 active low", {7'b0, pin_out[4]}, 8'h00);
    clr = 1'b1; tick(); clr = 1'b0;
    check_all("R9 clear");
    check("R9 registers cleared", pin_out & 8'hAC, 8'h08);
    for (int k = 0; k < 6; k++) begin
      din = 10'(k * 101 + 3);
      tick();
      check_all("R9 config intact after clear");
    end
    rst_n = 1'b0; #1; qm = '0; hold_rst = 1;
    check_all("R10 async clear");
    #4 rst_n = 1'b1;
    din = 10'h3FF;
    tick();
    check_all("R10 held during sync release");
    tick(); hold_rst = 0;
    check_all("R10 held second edge");
    tick();
    check_all("R10 running again");

    for (int c = 0; c < 5; c++) begin
      cfgv = '0;
      for (int t = 0; t < NM*NP; t++) begin
        if ($urandom % 8 != 0) begin
          for (int s = 0; s < NS; s++) begin
            int unsigned r = $urandom % 16;
            if (r < 2) cfgv[t*TW + 2*s] = 1'b1;
            else if (r < 4) cfgv[t*TW + 2*s + 1] = 1'b1;
            else if (r == 4) cfgv[t*TW + 2*s +: 2] = 2'b11;
          end
        end
      end
      for (int m = 0; m < NM; m++) cfgv[FW + 3*m +: 3] = 3'($urandom);
      load_cfg();
      check_all("R8 after load");
      for (int k = 0; k < 150; k++) begin
        din = 10'($urandom); pin_in = 8'($urandom);
        clr = ($urandom % 16 == 0);
        tick();
        clr = 1'b0;
        check_all("R1 R2 R3 R4 R5 R6 R7 R9 random");
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule